// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer whose write port and read port run on independent clocks. Words of `DW` bits (9 by default) are pushed on the write clock and popped on the read clock into a registered output. The buffer holds `DEPTH` words, and `DEPTH` is a power of two from 256 to 8192. Four active-low status flags report the fill level. Empty and almost-empty belong to the read clock, and full and almost-full belong to the write clock. Each side computes its flags from its own pointer and a Gray-coded copy of the other side's pointer that has passed through two synchroniser flops.

The dual-purpose pin `wen2_ld` is sampled while reset is low, and its level fixes the operating mode until the next reset. High selects two-enable mode: a write needs `wen1_n` low and `wen2_ld` high, and both thresholds are fixed at 7. Low selects offset mode: the thresholds come from the `ae_ofs` and `af_ofs` buses, and `wen2_ld` becomes a load strobe. While the strobe is low, writes and reads are meant for offset storage outside this block, so the buffer ignores them.

Top module: `fifo_pflag_dc`

## Requirements
- R1: A word is stored at a rising `wr_clk` edge only if `wen1_n`=0, `wen2_ld`=1 and `full_n`=1. A full buffer ignores write attempts, and the words already stored keep their order.
- R2: A word is popped into `rd_data` at a rising `rd_clk` edge only if `ren1_n`=0, `ren2_n`=0 and `empty_n`=1. An ignored read, including a read of an empty buffer, leaves `rd_data` at the last word read.
- R3: The level of `wen2_ld` while `rst_n`=0 selects the mode. Level 1 gives two-enable mode and level 0 gives offset mode, where `ae_ofs` and `af_ofs` set the thresholds.
- R4: In offset mode, while `wen2_ld`=0, write and read attempts change neither the stored words, the flags nor `rd_data`.
- R5: While `rst_n`=0, and after its release until the first access, `empty_n`=0, `aempty_n`=0, `full_n`=1, `afull_n`=1 and `rd_data`=0. The buffer accepts no access during reset.
- R6: Once settled, `aempty_n`=0 when the buffer holds n or fewer words and `aempty_n`=1 when it holds n+1 or more.
- R7: Once settled, `afull_n`=0 when the buffer holds DEPTH−m or more words and `afull_n`=1 otherwise.
- R8: In two-enable mode n=m=7, whatever `ae_ofs` and `af_ofs` carry.
- R9: Once settled, `empty_n`=0 exactly when the buffer holds no word and `full_n`=0 exactly when it holds DEPTH words.
- R10: After one word is written into an empty buffer, `empty_n` rises no later than the fourth `rd_clk` edge after the write edge. A read enabled for the next edge presents that word at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low reset, sampled by both clocks |
| wr_clk | input | 1 | Write clock |
| wr_data | input | DW | Word to store |
| wen1_n | input | 1 | Write enable, active low |
| wen2_ld | input | 1 | Second write enable (high active) or load strobe (low active), role latched at reset |
| ae_ofs | input | log2(DEPTH) | Almost-empty threshold n in offset mode |
| af_ofs | input | log2(DEPTH) | Almost-full threshold m in offset mode |
| full_n | output | 1 | Low when full, write-clock domain |
| afull_n | output | 1 | Low when almost full, write-clock domain |
| rd_clk | input | 1 | Read clock |
| ren1_n | input | 1 | Read enable 1, active low |
| ren2_n | input | 1 | Read enable 2, active low |
| rd_data | output | DW | Registered output word |
| empty_n | output | 1 | Low when empty, read-clock domain |
| aempty_n | output | 1 | Low when almost empty, read-clock domain |

## Verification
A read result is due at the same `rd_clk` edge that accepts the read. The bench therefore drives enables on a falling edge and compares `rd_data` on the next falling edge. Flags driven by the local pointer move at the accepting edge. Flags that depend on the other domain lag by up to three edges of their own clock: one source register, then two synchroniser flops. The bench waits eight read-clock periods before every flag comparison, so that the slower clock has passed that window. The one latency that is measured exactly is the first-word case, which is counted edge by edge against a bound of four.

// File: rtl/fifo_pflag_pkg.sv
package fifo_pflag_pkg;
  // threshold used for both flags when the second-enable mode is active
  localparam int unsigned PRESET_OFS = 7;

  typedef enum logic {
    MODE_TWO_EN = 1'b0,
    MODE_PROG   = 1'b1
  } fifo_mode_e;
endpackage

// File: rtl/fifo_ptr_cross.sv
// Registers a pointer in Gray code in its source domain, then brings it
// through two flops into the destination domain and back to binary.
module fifo_ptr_cross #(
  parameter int PW = 9
) (
  input  logic          rst_n,
  input  logic          src_clk,
  input  logic [PW-1:0] src_bin_nx,
  input  logic          dst_clk,
  output logic [PW-1:0] dst_bin
);
  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] src_gray;
  logic [PW-1:0] meta_q [2];

  always_ff @(posedge src_clk) begin
    if (!rst_n) src_gray <= '0;
    else        src_gray <= to_gray(src_bin_nx);
  end

  always_ff @(posedge dst_clk) begin
    if (!rst_n) begin
      meta_q[0] <= '0;
      meta_q[1] <= '0;
    end else begin
      meta_q[0] <= src_gray;
      meta_q[1] <= meta_q[0];
    end
  end

  assign dst_bin = from_gray(meta_q[1]);
endmodule

// File: rtl/fifo_ram.sv
module fifo_ram #(
  parameter int DW    = 9,
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          rst_n,
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= cells[raddr];
  end
endmodule

// File: rtl/fifo_wr_side.sv
module fifo_wr_side
  import fifo_pflag_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wen1_n,
  input  logic          wen2_ld,
  input  logic [AW-1:0] m_ofs,
  input  logic [PW-1:0] rd_ptr_sync,
  output logic          push,
  output logic [PW-1:0] wr_ptr_nx,
  output logic [AW-1:0] waddr,
  output logic          full_n,
  output logic          afull_n
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  function automatic logic [PW-1:0] fill(input logic [PW-1:0] head, input logic [PW-1:0] tail);
    return head - tail;
  endfunction

  fifo_mode_e    mode_q;
  logic [PW-1:0] wr_ptr;
  logic [AW-1:0] m_eff;
  logic [PW-1:0] level_now, level_nx, af_limit;

  assign push      = rst_n && !wen1_n && wen2_ld && full_n;
  assign wr_ptr_nx = wr_ptr + PW'(push);
  assign waddr     = wr_ptr[AW-1:0];
  assign m_eff     = (mode_q == MODE_PROG) ? m_ofs : AW'(PRESET_OFS);
  assign af_limit  = DEPTH_P - {1'b0, m_eff};
  assign level_now = fill(wr_ptr, rd_ptr_sync);
  assign level_nx  = fill(wr_ptr_nx, rd_ptr_sync);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= wen2_ld ? MODE_TWO_EN : MODE_PROG;
      wr_ptr  <= '0;
      full_n  <= 1'b1;
      afull_n <= 1'b1;
    end else begin
      wr_ptr  <= wr_ptr_nx;
      full_n  <= (level_nx != DEPTH_P);
      afull_n <= (level_nx < af_limit);
    end
  end

  // R1: the write pointer never runs more than DEPTH ahead of the read pointer
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    level_now <= DEPTH_P);
  // R7: a full buffer is also almost full
  a_r7_full_in_afull: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> !afull_n);
  // R3: the mode stays put once reset has been released
  a_r3_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q));
endmodule

// File: rtl/fifo_rd_side.sv
module fifo_rd_side
  import fifo_pflag_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren1_n,
  input  logic          ren2_n,
  input  logic          ld_pin,
  input  logic [AW-1:0] n_ofs,
  input  logic [PW-1:0] wr_ptr_sync,
  output logic          pop,
  output logic [PW-1:0] rd_ptr_nx,
  output logic [AW-1:0] raddr,
  output logic          empty_n,
  output logic          aempty_n
);
  function automatic logic [PW-1:0] fill(input logic [PW-1:0] head, input logic [PW-1:0] tail);
    return head - tail;
  endfunction

  fifo_mode_e    mode_q;
  logic [PW-1:0] rd_ptr;
  logic [AW-1:0] n_eff;
  logic [PW-1:0] level_now, level_nx;
  logic          load_window;

  assign load_window = (mode_q == MODE_PROG) && !ld_pin;
  assign pop         = rst_n && !ren1_n && !ren2_n && empty_n && !load_window;
  assign rd_ptr_nx   = rd_ptr + PW'(pop);
  assign raddr       = rd_ptr[AW-1:0];
  assign n_eff       = (mode_q == MODE_PROG) ? n_ofs : AW'(PRESET_OFS);
  assign level_now   = fill(wr_ptr_sync, rd_ptr);
  assign level_nx    = fill(wr_ptr_sync, rd_ptr_nx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= ld_pin ? MODE_TWO_EN : MODE_PROG;
      rd_ptr   <= '0;
      empty_n  <= 1'b0;
      aempty_n <= 1'b0;
    end else begin
      rd_ptr   <= rd_ptr_nx;
      empty_n  <= (level_nx != '0);
      aempty_n <= (level_nx > {1'b0, n_eff});
    end
  end

  // R2: no word visible on this side means the empty flag is already low
  a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (level_now == '0) |-> !empty_n);
  // R6: an empty buffer is also almost empty
  a_r6_empty_in_aempty: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);
  // R3: the read side keeps its mode once reset has been released
  a_r3_rd_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q));
endmodule

// File: rtl/fifo_pflag_dc.sv
module fifo_pflag_dc #(
  parameter int DW    = 9,
  parameter int DEPTH = 256
) (
  input  logic                     rst_n,
  input  logic                     wr_clk,
  input  logic [DW-1:0]            wr_data,
  input  logic                     wen1_n,
  input  logic                     wen2_ld,
  input  logic [$clog2(DEPTH)-1:0] ae_ofs,
  input  logic [$clog2(DEPTH)-1:0] af_ofs,
  output logic                     full_n,
  output logic                     afull_n,
  input  logic                     rd_clk,
  input  logic                     ren1_n,
  input  logic                     ren2_n,
  output logic [DW-1:0]            rd_data,
  output logic                     empty_n,
  output logic                     aempty_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          push, pop;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wr_ptr_nx, rd_ptr_nx, wr_ptr_at_rd, rd_ptr_at_wr;

  fifo_wr_side #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
    .clk(wr_clk), .rst_n(rst_n), .wen1_n(wen1_n), .wen2_ld(wen2_ld),
    .m_ofs(af_ofs), .rd_ptr_sync(rd_ptr_at_wr), .push(push),
    .wr_ptr_nx(wr_ptr_nx), .waddr(waddr), .full_n(full_n), .afull_n(afull_n)
  );

  fifo_rd_side #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_rd (
    .clk(rd_clk), .rst_n(rst_n), .ren1_n(ren1_n), .ren2_n(ren2_n),
    .ld_pin(wen2_ld), .n_ofs(ae_ofs), .wr_ptr_sync(wr_ptr_at_rd), .pop(pop),
    .rd_ptr_nx(rd_ptr_nx), .raddr(raddr), .empty_n(empty_n), .aempty_n(aempty_n)
  );

  fifo_ptr_cross #(.PW(PW)) u_w2r (
    .rst_n(rst_n), .src_clk(wr_clk), .src_bin_nx(wr_ptr_nx),
    .dst_clk(rd_clk), .dst_bin(wr_ptr_at_rd)
  );

  fifo_ptr_cross #(.PW(PW)) u_r2w (
    .rst_n(rst_n), .src_clk(rd_clk), .src_bin_nx(rd_ptr_nx),
    .dst_clk(wr_clk), .dst_bin(rd_ptr_at_wr)
  );

  fifo_ram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .rst_n(rst_n), .wclk(wr_clk), .we(push), .waddr(waddr), .wdata(wr_data),
    .rclk(rd_clk), .re(pop), .raddr(raddr), .rdata(rd_data)
  );
endmodule

// File: tb/sim_fifo_pflag_dc.sv
module sim_fifo_pflag_dc;
  localparam int DW = 9;
  localparam int DEPTH = 256;
  localparam int AW = $clog2(DEPTH);
  localparam time WCLK_PERIOD = 10;
  localparam time RCLK_PERIOD = 14;

  // {writes[21:13], reads[12:4], flags {empty_n,aempty_n,afull_n,full_n}}
  localparam int NVEC = 13;
  localparam logic [21:0] VEC [NVEC] = '{
    {9'd1,   9'd0,   4'b1011},  // fill 1   : R6 R9
    {9'd6,   9'd0,   4'b1011},  // fill 7   : R6 R8
    {9'd1,   9'd0,   4'b1111},  // fill 8   : R6 R8 (ae_ofs=20 not used)
    {9'd240, 9'd0,   4'b1111},  // fill 248 : R7 R8 (af_ofs=20 not used)
    {9'd1,   9'd0,   4'b1101},  // fill 249 : R7
    {9'd7,   9'd0,   4'b1100},  // fill 256 : R9
    {9'd3,   9'd0,   4'b1100},  // overflow ignored : R1
    {9'd0,   9'd1,   4'b1101},  // fill 255
    {9'd0,   9'd7,   4'b1111},  // fill 248 : R7
    {9'd0,   9'd240, 4'b1111},  // fill 8
    {9'd0,   9'd1,   4'b1011},  // fill 7 : R6
    {9'd0,   9'd7,   4'b0011},  // fill 0 : R9
    {9'd0,   9'd2,   4'b0011}   // underflow ignored : R2
  };

  logic rst_n = 1'b0, wr_clk = 1'b0, rd_clk = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic wen1_n = 1'b1, wen2_ld = 1'b1, ren1_n = 1'b1, ren2_n = 1'b0;
  logic [AW-1:0] ae_ofs = '0, af_ofs = '0;
  logic full_n, afull_n, empty_n, aempty_n;
  logic [DW-1:0] rd_data;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] q [$];
  logic [DW-1:0] wseq = 9'h040;
  logic [DW-1:0] last_rd = '0;
  bit prog = 1'b0;

  always #(WCLK_PERIOD / 2) wr_clk = ~wr_clk;
  always #(RCLK_PERIOD / 2) rd_clk = ~rd_clk;

  fifo_pflag_dc #(.DW(DW), .DEPTH(DEPTH)) u0 (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_data(wr_data), .wen1_n(wen1_n),
    .wen2_ld(wen2_ld), .ae_ofs(ae_ofs), .af_ofs(af_ofs), .full_n(full_n),
    .afull_n(afull_n), .rd_clk(rd_clk), .ren1_n(ren1_n), .ren2_n(ren2_n),
    .rd_data(rd_data), .empty_n(empty_n), .aempty_n(aempty_n)
  );

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_flags(input string tag, input logic [3:0] exp);
    chk(tag, {12'd0, empty_n, aempty_n, afull_n, full_n}, {12'd0, exp});
  endtask

  task automatic settle();
    repeat (8) @(negedge rd_clk);
    @(negedge wr_clk);
  endtask

  task automatic do_reset(input logic ld);
    rst_n = 1'b0; wen2_ld = ld; wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b0;
    prog = !ld;
    q.delete();
    last_rd = '0;
    repeat (5) @(negedge rd_clk);
    @(negedge wr_clk);
    rst_n = 1'b1;
    settle();
  endtask

  task automatic do_write(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wen1_n = 1'b0;
      wr_data = wseq;
      if (wen2_ld && q.size() < DEPTH) q.push_back(wseq);
      wseq = wseq + 1'b1;
    end
    @(negedge wr_clk);
    wen1_n = 1'b1;
  endtask

  task automatic do_read(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge rd_clk);
      ren1_n = 1'b0;
      @(negedge rd_clk);
      ren1_n = 1'b1;
      if (!ren2_n && q.size() > 0 && !(prog && !wen2_ld)) last_rd = q.pop_front();
      chk(tag, {7'd0, rd_data}, {7'd0, last_rd});
    end
  endtask

  initial begin
    #(200000 * WCLK_PERIOD);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int edges;
    // ---- two-enable mode, offsets held away from 7 to expose misuse (R8)
    ae_ofs = AW'(20); af_ofs = AW'(20);
    do_reset(1'b1);
    chk_flags("R5 reset flags", 4'b0011);
    chk("R5 reset data", {7'd0, rd_data}, 16'd0);

    // write with second enable low is ignored
    wen2_ld = 1'b0;
    do_write(3);
    wen2_ld = 1'b1;
    settle();
    chk_flags("R1 wen2 low ignored", 4'b0011);

    // first-word latency
    @(negedge wr_clk);
    wen1_n = 1'b0; wr_data = 9'h1A5;
    @(negedge wr_clk);
    wen1_n = 1'b1;
    edges = 0;
    while (!empty_n && edges < 10) begin
      @(negedge rd_clk);
      edges++;
    end
    chk("R10 empty_n rise edges", 16'(edges <= 4), 16'd1);
    ren1_n = 1'b0;
    @(negedge rd_clk);
    ren1_n = 1'b1;
    chk("R10 first word", {7'd0, rd_data}, 16'h1A5);
    last_rd = 9'h1A5;
    settle();
    chk_flags("R9 drained", 4'b0011);

    // ---- vector table
    for (int v = 0; v < NVEC; v++) begin
      do_write(int'(VEC[v][21:13]));
      do_read(int'(VEC[v][12:4]), "R1 R2 data order");
      settle();
      chk_flags($sformatf("row %0d R6 R7 R8 R9 flags", v), VEC[v][3:0]);
    end

    // ---- offset mode: n=3, m=10
    ae_ofs = AW'(3); af_ofs = AW'(10);
    do_reset(1'b0);
    chk_flags("R5 reset flags offset mode", 4'b0011);
    do_write(2);          // strobe low: diverted away from the buffer
    settle();
    chk_flags("R4 write during load ignored", 4'b0011);
    wen2_ld = 1'b1;
    do_write(3);
    settle();
    chk_flags("R6 fill 3 with n=3", 4'b1011);
    do_write(1);
    settle();
    chk_flags("R3 R6 fill 4 with n=3", 4'b1111);
    do_write(241);
    settle();
    chk_flags("R7 fill 245 with m=10", 4'b1111);
    do_write(1);
    settle();
    chk_flags("R3 R7 fill 246 with m=10", 4'b1101);

    // second read enable high blocks the read
    ren2_n = 1'b1;
    do_read(2, "R2 ren2 high data");
    ren2_n = 1'b0;
    settle();
    chk_flags("R2 ren2 high flags", 4'b1101);

    // strobe low blocks the read
    wen2_ld = 1'b0;
    do_read(2, "R4 read during load data");
    settle();
    chk_flags("R4 read during load flags", 4'b1101);
    wen2_ld = 1'b1;
    do_read(1, "R4 first word after load");
    settle();
    chk_flags("R7 fill 245 after read", 4'b1111);

    summary();
    $finish;
  end
endmodule